// File: doc/BRIEF.md
# Front-End Configuration Serial Port

This block sends one configuration command down a chain of front-end chips. On a start strobe it captures a 16-bit pulse-count word, an address/command word, a data word and a read flag. It then drives a configuration clock enable, a load strobe and a serial data line. One field of the count word sets the number of address/command clock pulses, scaled by eight. The other field sets the number of data-phase clock pulses, which is not scaled. The load strobe is high only while the data-phase pulses run.

Each configuration pulse takes two system clocks: one with the enable low, then one with the enable high. The serial data changes only in the low half, so it is stable at the rising edge of the gated clock. For a read command, the block copies the readback input to a registered output on every system clock from a fixed clock count after the start until the command ends. The system that drives the block uses the busy flag to space its commands.

Top module: `cfg_serial_port`

## Requirements
- R1: The count word is split into two fields. Bits [2:0] times 8 give the number of address/command pulses. Bits [15:3] give the number of data pulses, unscaled. Value 0x0009 gives 8 address pulses followed by 1 data pulse.
- R2: Each pulse is one system clock with `cfg_clk_en` low followed by one with it high. The first low half is the cycle after the edge that accepts `start`, and the pulses follow one another with no gap.
- R3: `cfg_load` is low for the whole of the address/command pulses. It is high for both halves of every data pulse, and it is low whenever the block is idle.
- R4: `cfg_sdo` presents bits most significant first. It first sends `cmd_word` bits, one per address pulse, then `data_word` bits, one per data pulse. Data bits beyond the pulse count are dropped, and pulses beyond the data word width send 0. The line changes only while `cfg_clk_en` is low. Inputs are captured when `start` is accepted.
- R5: `busy` rises after the edge that accepts `start`. It stays high for exactly 2×(total pulses) system clocks.
- R6: A `start` that arrives while `busy` is high is ignored. The running command continues unchanged.
- R7: If both count fields are zero, the command completes at once: no pulse is produced and `busy` stays low.
- R8: `rd_req` is captured at start. For a read command, `rb_out` at edge k after the start edge equals `rb_in` sampled at that edge, for every k from 19 up to and including the edge where `busy` falls. At all other times `rb_out` is 0.
- R9: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command start strobe |
| count_cfg | input | 16 | Pulse-count word: [2:0] address count (scaled by 8), [15:3] data count |
| cmd_word | input | CMD_W (56) | Address/command bits, sent most significant first |
| data_word | input | DAT_W (16) | Data bits, sent most significant first |
| rd_req | input | 1 | Command is a read; enables readback forwarding |
| rb_in | input | 1 | Serial readback from the front-end chain |
| cfg_clk_en | output | 1 | Configuration clock enable (high half of each pulse) |
| cfg_load | output | 1 | Load strobe, high during data pulses |
| cfg_sdo | output | 1 | Serial configuration data |
| busy | output | 1 | Command in progress |
| rb_out | output | 1 | Forwarded readback |

## Verification
The assertions check the per-cycle rules on every clock. Each enable pulse lasts one clock and the data line holds still across the rising half. Load and enable are low when idle, load never drops in the middle of a command, a start during a command does not restart the pulse phase, and readback is quiet when idle. Only the bench scenarios can show the pulse totals for each count value, the exact bit order and the dropping of low data bits. The same applies to the zero-count case, the input capture at start, and the exact edge at which readback forwarding opens and closes.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int CMD_W    = 56,
  parameter int DAT_W    = 16,
  parameter int RB_START = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      count_cfg,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic [DAT_W-1:0] data_word,
  input  logic             rd_req,
  input  logic             rb_in,
  output logic             cfg_clk_en,
  output logic             cfg_load,
  output logic             cfg_sdo,
  output logic             busy,
  output logic             rb_out
);

  localparam int AC_W  = 6;
  localparam int DT_W  = 13;
  localparam int CYC_W = $clog2(RB_START + 1);

  logic [AC_W-1:0]  ac_left;
  logic [DT_W-1:0]  dt_left;
  logic [CMD_W-1:0] cmd_sr;
  logic [DAT_W-1:0] dat_sr;
  logic [CYC_W-1:0] cyc;
  logic             rd_q;

  wire [AC_W-1:0] ac_init = {count_cfg[2:0], 3'b000};
  wire            go      = start && !busy;
  wire            nz      = |count_cfg;
  wire            ac_on   = ac_left != '0;
  wire [AC_W-1:0] ac_nxt  = ac_on ? ac_left - AC_W'(1) : ac_left;
  wire [DT_W-1:0] dt_nxt  = ac_on ? dt_left : dt_left - DT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_left    <= '0;
      dt_left    <= '0;
      cmd_sr     <= '0;
      dat_sr     <= '0;
      cyc        <= '0;
      rd_q       <= 1'b0;
      busy       <= 1'b0;
      cfg_clk_en <= 1'b0;
      cfg_load   <= 1'b0;
      cfg_sdo    <= 1'b0;
    end else if (go) begin
      rd_q       <= rd_req;
      cyc        <= CYC_W'(1);
      ac_left    <= ac_init;
      dt_left    <= count_cfg[15:3];
      busy       <= nz;
      cfg_clk_en <= 1'b0;
      cmd_sr     <= cmd_word;
      dat_sr     <= data_word;
      if (ac_init != '0) begin
        cfg_load <= 1'b0;
        cfg_sdo  <= cmd_word[CMD_W-1];
        cmd_sr   <= cmd_word << 1;
      end else if (nz) begin
        cfg_load <= 1'b1;
        cfg_sdo  <= data_word[DAT_W-1];
        dat_sr   <= data_word << 1;
      end else begin
        cfg_load <= 1'b0;
        cfg_sdo  <= 1'b0;
      end
    end else if (busy) begin
      if (int'(cyc) < RB_START) cyc <= cyc + CYC_W'(1);
      if (!cfg_clk_en) begin
        cfg_clk_en <= 1'b1;
      end else begin
        cfg_clk_en <= 1'b0;
        ac_left    <= ac_nxt;
        dt_left    <= dt_nxt;
        if (ac_nxt != '0) begin
          cfg_sdo <= cmd_sr[CMD_W-1];
          cmd_sr  <= cmd_sr << 1;
        end else if (dt_nxt != '0) begin
          cfg_load <= 1'b1;
          cfg_sdo  <= dat_sr[DAT_W-1];
          dat_sr   <= dat_sr << 1;
        end else begin
          busy     <= 1'b0;
          cfg_load <= 1'b0;
          cfg_sdo  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rb_out <= 1'b0;
    else        rb_out <= (busy && rd_q && int'(cyc) >= RB_START) ? rb_in : 1'b0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cfg_clk_en && !cfg_load)); // R3
  AST_HIGH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_en |=> !cfg_clk_en); // R2
  AST_SDO_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk_en) |-> $stable(cfg_sdo)); // R4
  AST_LOAD_FALL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_load) |-> !busy); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_clk_en && start) |=> cfg_clk_en); // R6
  AST_RB_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !rb_out); // R8

endmodule

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;
  localparam int CMD_W = 56;
  localparam int DAT_W = 16;

  logic clk = 0, rst_n = 0, start = 0, rd_req = 0, rb_in = 0;
  logic [15:0] count_cfg = '0;
  logic [CMD_W-1:0] cmd_word = '0;
  logic [DAT_W-1:0] data_word = '0;
  logic cfg_clk_en, cfg_load, cfg_sdo, busy, rb_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_serial_port #(.CMD_W(CMD_W), .DAT_W(DAT_W), .RB_START(19)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .count_cfg(count_cfg),
    .cmd_word(cmd_word), .data_word(data_word), .rd_req(rd_req), .rb_in(rb_in),
    .cfg_clk_en(cfg_clk_en), .cfg_load(cfg_load), .cfg_sdo(cfg_sdo),
    .busy(busy), .rb_out(rb_out));

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic exp_sdo(int p, int nac, logic [CMD_W-1:0] c, logic [DAT_W-1:0] d);
    int q;
    if (p < nac) return (p < CMD_W) ? c[CMD_W-1-p] : 1'b0;
    q = p - nac;
    return (q < DAT_W) ? d[DAT_W-1-q] : 1'b0;
  endfunction

  task automatic run_cmd(logic [15:0] cnt, logic [CMD_W-1:0] c, logic [DAT_W-1:0] d,
                         logic rd, bit glitch);
    int nac, ndt, n, pulses, p;
    logic prev_rb, prev_clk, eb;
    string tb5;
    nac = int'(cnt[2:0]) * 8;
    ndt = int'(cnt[15:3]);
    n = nac + ndt;
    pulses = 0;
    prev_clk = 0;
    tb5 = (n == 0) ? "R7" : (glitch ? "R6" : "R5");
    @(negedge clk);
    count_cfg = cnt; cmd_word = c; data_word = d; rd_req = rd; start = 1;
    rb_in = 1'($urandom); prev_rb = rb_in;
    for (int k = 0; k <= 2*n + 2; k++) begin
      @(negedge clk);
      eb = (k < 2*n);
      p = k / 2;
      chk(tb5, busy, eb);
      chk("R2", cfg_clk_en, eb && (k % 2 == 1));
      chk("R3", cfg_load, eb && (p >= nac));
      chk("R4", cfg_sdo, eb ? exp_sdo(p, nac, c, d) : 1'b0);
      chk("R8", rb_out, (rd && k >= 19 && k <= 2*n) ? prev_rb : 1'b0);
      if (cfg_clk_en && !prev_clk) pulses++;
      prev_clk = cfg_clk_en;
      start = glitch && (k == 4);
      if (start) count_cfg = 16'($urandom);
      if (k == 0) begin
        cmd_word = {$urandom, $urandom};
        data_word = 16'($urandom);
        rd_req = ~rd;
      end
      rb_in = 1'($urandom);
      prev_rb = rb_in;
    end
    chk_int(n == 0 ? "R7" : "R1", pulses, n);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    start = 1; count_cfg = 16'hFFFF;
    @(negedge clk);
    chk("R9", busy, 0); chk("R9", cfg_clk_en, 0); chk("R9", cfg_load, 0);
    chk("R9", cfg_sdo, 0); chk("R9", rb_out, 0);
    start = 0;
    rst_n = 1;
    // R1: 0x0009 -> 8 address pulses then one data pulse, read enabled
    run_cmd(16'h0009, {8'hB5, 48'h0}, 16'h855A, 1'b1, 0);
    // R7: zero counts
    run_cmd(16'h0000, '1, '1, 1'b1, 0);
    // address only, full width
    run_cmd(16'h0007, {$urandom, $urandom}, 16'hFFFF, 1'b0, 0);
    // R4: data longer than word -> trailing zeros, read window
    run_cmd({13'd20, 3'd0}, '0, 16'hFFFF, 1'b1, 0);
    // R4: short data -> low bits dropped
    run_cmd({13'd5, 3'd0}, '0, 16'hA5C3, 1'b0, 0);
    // R6: start while busy
    run_cmd(16'h0019, {$urandom, $urandom}, 16'h1234, 1'b1, 1);
    for (int i = 0; i < 40; i++) begin
      logic [15:0] cc;
      cc = {13'($urandom % 24), 3'($urandom)};
      run_cmd(cc, {$urandom, $urandom}, 16'($urandom), 1'($urandom), (i % 5 == 0) && cc != 0 && cc[15:3] + 8*cc[2:0] >= 3);
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R5 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule